// File: doc/BRIEF.md
# Stereo Sample Error Concealment

This block repairs audio samples that an upstream corrector has marked as uncorrectable. Samples of a stereo stream arrive one at a time over a valid/ready input, each tagged with its channel, a 16-bit two's-complement value and an error flag. Each channel has its own concealment lane. A lane keeps one sample pending, so it knows whether the following sample of that channel is good or flagged before it releases the pending one.

A flagged sample followed by a good sample is replaced by the midpoint of the last good value and that good sample. This covers both an isolated error and the last sample of a longer run. A flagged sample followed by another flagged sample is replaced by the last good value, which holds the signal. If a channel starts with flagged samples, the held value is zero. The block records whether any interpolation or any hold happened, and reports the result as a 2-bit code each time `frame_tick` closes a window.

Each lane is a small state machine with three states. `LN_EMPTY` means nothing is pending (after reset). `LN_GOOD` means a good sample is pending. `LN_BAD` means a flagged sample is pending. Every accepted sample of the lane's channel moves the lane to `LN_GOOD` if the sample is clean, or to `LN_BAD` if it is flagged. The sample that was pending is emitted in that same step, unless the lane was in `LN_EMPTY`.

Top module: `audio_conceal`

## Requirements
- R1: The output lags by one sample per channel. The first sample of a channel after reset produces no output. When sample n+1 of a channel is accepted, sample n of that channel appears on the output in the following cycle.
- R2: A sample whose error flag is 0 leaves the block unchanged, with `out_fix` = 0.
- R3: An isolated flagged sample, with good samples on both sides, is replaced by floor((previous + next) / 2), and `out_fix` = 1.
- R4: In a run of two or more flagged samples, every sample except the last is replaced by the last good value of that channel, with `out_fix` = 1.
- R5: The last flagged sample of a run, which is followed by a good sample, is replaced by floor((last good value + that good sample) / 2), with `out_fix` = 1.
- R6: Channel tag 0 is left and 1 is right. The two channels are concealed independently, whatever the interleaving. `out_chan` carries the tag of the emitted sample.
- R7: Before the first good sample of a channel, the last good value is 0. This applies to both hold and interpolation.
- R8: The midpoint is formed at one bit wider than the sample and never overflows. For example, 32767 with 32767 gives 32767, and -32768 with -32768 gives -32768.
- R9: On each `frame_tick`, `frame_stat` latches the window's code and keeps it until the next tick. Bit 0 is set if any interpolation occurred. Bit 1 is set if any hold occurred. So 00 means neither, 01 means interpolation only, 10 means hold only, and 11 means both. The window then restarts empty.
- R10: `in_ready` is low while `out_valid` is high and `out_ready` is low. During such a stall, `out_valid`, `out_data` and `out_chan` stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Block can accept a sample |
| in_chan | input | 1 | Channel tag of the input (0 left, 1 right) |
| in_data | input | 16 | Signed input sample |
| in_err | input | 1 | Input sample is uncorrectable |
| out_valid | output | 1 | Output sample present |
| out_ready | input | 1 | Downstream accepts the output |
| out_chan | output | 1 | Channel tag of the output |
| out_data | output | 16 | Signed concealed sample |
| out_fix | output | 1 | Output value was substituted |
| frame_tick | input | 1 | Closes the statistics window |
| frame_stat | output | 2 | Latched statistics code of the last window |

## Verification
The hardest situation to reach from the ports is a pair of lanes that are both part-way through concealment: one channel in the middle of a flagged run while the other sits on a single flagged sample. The channel-independence scenario creates this by interleaving left and right samples so that each lane's pending sample is flagged at the same time. The bench then checks each output's tag and value against the model of its own channel. The overflow corners are reached by surrounding a flagged sample with full-scale values of the same sign.

// File: rtl/conceal_pkg.sv
package conceal_pkg;

    typedef enum logic [1:0] {
        LN_EMPTY = 2'd0,
        LN_GOOD  = 2'd1,
        LN_BAD   = 2'd2
    } lane_state_t;

    typedef struct packed {
        logic hold;
        logic interp;
    } stat_code_t;

endpackage

// File: rtl/conceal_lane.sv
module conceal_lane
    import conceal_pkg::*;
#(
    parameter int SAMPLE_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                take_i,
    input  logic [SAMPLE_W-1:0] data_i,
    input  logic                err_i,
    output logic                emit_o,
    output logic [SAMPLE_W-1:0] emit_data_o,
    output logic                emit_interp_o,
    output logic                emit_hold_o
);

    localparam int SUM_W = SAMPLE_W + 1;

    lane_state_t         state_q, state_d;
    logic [SAMPLE_W-1:0] pend_q;
    logic [SAMPLE_W-1:0] base_q;
    logic [SUM_W-1:0]    sum_w;
    logic [SAMPLE_W-1:0] mid_w;

    // widened sum, shifted right arithmetically, cannot overflow
    always_comb begin
        sum_w = {base_q[SAMPLE_W-1], base_q} + {data_i[SAMPLE_W-1], data_i};
        mid_w = sum_w[SUM_W-1:1];
    end

    // state register and sample storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LN_EMPTY;
            pend_q  <= '0;
            base_q  <= '0;
        end else begin
            state_q <= state_d;
            if (take_i) begin
                pend_q <= data_i;
                if (state_q == LN_GOOD) begin
                    base_q <= pend_q;
                end
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (take_i) begin
            state_d = err_i ? LN_BAD : LN_GOOD;
        end
    end

    // outputs
    always_comb begin
        emit_o        = 1'b0;
        emit_data_o   = pend_q;
        emit_interp_o = 1'b0;
        emit_hold_o   = 1'b0;
        if (take_i) begin
            unique case (state_q)
                LN_EMPTY: begin
                    emit_o = 1'b0;
                end
                LN_GOOD: begin
                    emit_o      = 1'b1;
                    emit_data_o = pend_q;
                end
                LN_BAD: begin
                    emit_o = 1'b1;
                    if (err_i) begin
                        emit_data_o = base_q;
                        emit_hold_o = 1'b1;
                    end else begin
                        emit_data_o   = mid_w;
                        emit_interp_o = 1'b1;
                    end
                end
                default: begin
                    emit_o = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/conceal_stats.sv
module conceal_stats
    import conceal_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ev_interp_i,
    input  logic       ev_hold_i,
    input  logic       tick_i,
    output stat_code_t code_o
);

    stat_code_t seen_q;
    stat_code_t code_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= '0;
            code_q <= '0;
        end else if (tick_i) begin
            code_q.hold   <= seen_q.hold   | ev_hold_i;
            code_q.interp <= seen_q.interp | ev_interp_i;
            seen_q        <= '0;
        end else begin
            seen_q.hold   <= seen_q.hold   | ev_hold_i;
            seen_q.interp <= seen_q.interp | ev_interp_i;
        end
    end

    assign code_o = code_q;

endmodule

// File: rtl/audio_conceal.sv
module audio_conceal
    import conceal_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int NUM_CHAN = 2,
    localparam int CHAN_W  = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [CHAN_W-1:0]   in_chan,
    input  logic [SAMPLE_W-1:0] in_data,
    input  logic                in_err,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [CHAN_W-1:0]   out_chan,
    output logic [SAMPLE_W-1:0] out_data,
    output logic                out_fix,
    input  logic                frame_tick,
    output logic [1:0]          frame_stat
);

    logic                accept;
    logic [NUM_CHAN-1:0] take;
    logic [NUM_CHAN-1:0] l_emit;
    logic [NUM_CHAN-1:0] l_interp;
    logic [NUM_CHAN-1:0] l_hold;
    logic [SAMPLE_W-1:0] l_data [NUM_CHAN];

    logic                sel_emit;
    logic                sel_interp;
    logic                sel_hold;
    logic [SAMPLE_W-1:0] sel_data;
    stat_code_t          stat_w;

    assign in_ready = !out_valid || out_ready;
    assign accept   = in_valid && in_ready;

    for (genvar g = 0; g < NUM_CHAN; g++) begin : g_lane
        assign take[g] = accept && (in_chan == CHAN_W'(g));

        conceal_lane #(
            .SAMPLE_W (SAMPLE_W)
        ) i_lane (
            .clk           (clk),
            .rst_n         (rst_n),
            .take_i        (take[g]),
            .data_i        (in_data),
            .err_i         (in_err),
            .emit_o        (l_emit[g]),
            .emit_data_o   (l_data[g]),
            .emit_interp_o (l_interp[g]),
            .emit_hold_o   (l_hold[g])
        );
    end

    always_comb begin
        sel_emit   = 1'b0;
        sel_interp = 1'b0;
        sel_hold   = 1'b0;
        sel_data   = '0;
        for (int c = 0; c < NUM_CHAN; c++) begin
            if (take[c]) begin
                sel_emit   = l_emit[c];
                sel_interp = l_interp[c];
                sel_hold   = l_hold[c];
                sel_data   = l_data[c];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_chan  <= '0;
            out_data  <= '0;
            out_fix   <= 1'b0;
        end else if (accept && sel_emit) begin
            out_valid <= 1'b1;
            out_chan  <= in_chan;
            out_data  <= sel_data;
            out_fix   <= sel_interp || sel_hold;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    conceal_stats i_stats (
        .clk         (clk),
        .rst_n       (rst_n),
        .ev_interp_i (sel_interp),
        .ev_hold_i   (sel_hold),
        .tick_i      (frame_tick),
        .code_o      (stat_w)
    );

    assign frame_stat = stat_w;

endmodule

// File: rtl/conceal_checker.sv
module conceal_checker #(
    parameter int SAMPLE_W = 16,
    parameter int CHAN_W   = 1
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic                in_ready,
    input logic                out_valid,
    input logic                out_ready,
    input logic [CHAN_W-1:0]   out_chan,
    input logic [SAMPLE_W-1:0] out_data,
    input logic                frame_tick,
    input logic [1:0]          frame_stat
);

    p_ready_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    p_stall_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_chan)));

    p_out_from_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(out_valid)) |-> $past(in_valid && in_ready));

    p_stat_steady_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(frame_tick) |-> $stable(frame_stat));

endmodule

bind audio_conceal conceal_checker #(
    .SAMPLE_W (SAMPLE_W),
    .CHAN_W   (CHAN_W)
) i_conceal_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_chan   (out_chan),
    .out_data   (out_data),
    .frame_tick (frame_tick),
    .frame_stat (frame_stat)
);

// File: tb/test_audio_conceal.sv
module test_audio_conceal;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [0:0]  in_chan = '0;
    logic [15:0] in_data = '0;
    logic        in_err = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [0:0]  out_chan;
    logic [15:0] out_data;
    logic        out_fix;
    logic        frame_tick = 1'b0;
    logic [1:0]  frame_stat;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    bit got_v;
    int got_d;
    bit got_c;
    bit got_f;

    always #10 clk = ~clk;

    audio_conceal i_audio_conceal (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_chan    (in_chan),
        .in_data    (in_data),
        .in_err     (in_err),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_chan   (out_chan),
        .out_data   (out_data),
        .out_fix    (out_fix),
        .frame_tick (frame_tick),
        .frame_stat (frame_stat)
    );

    function automatic int mid(int a, int b);
        return (a + b) >>> 1;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        frame_tick = 1'b0;
        out_ready = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic send(bit ch, int val, bit err);
        in_valid = 1'b1;
        in_chan  = ch;
        in_data  = val[15:0];
        in_err   = err;
        @(negedge clk);
        got_v = out_valid;
        got_d = $signed(out_data);
        got_c = out_chan;
        got_f = out_fix;
        in_valid = 1'b0;
    endtask

    task automatic exp_out(string req, bit ch, int val, bit fix);
        chk({req, " valid"}, got_v, 1);
        chk({req, " data"}, got_d, val);
        chk({req, " chan"}, got_c, ch);
        chk({req, " fix"}, got_f, fix);
    endtask

    task automatic exp_none(string req);
        chk({req, " no output"}, got_v, 0);
    endtask

    task automatic tick(output int code);
        frame_tick = 1'b1;
        @(negedge clk);
        frame_tick = 1'b0;
        code = frame_stat;
    endtask

    task automatic t_reset();
        do_reset();
        chk("reset out_valid", out_valid, 0);
        chk("reset in_ready", in_ready, 1);
        chk("R9 reset frame_stat", frame_stat, 0);
    endtask

    task automatic t_latency();
        do_reset();
        send(0, 100, 0); exp_none("R1 first sample");
        send(0, 200, 0); exp_out("R1 R2 good pass", 0, 100, 0);
        send(0, -7, 0);  exp_out("R2 good pass", 0, 200, 0);
    endtask

    task automatic t_isolated();
        do_reset();
        send(0, 100, 0);
        send(0, 5, 1);   exp_out("R2", 0, 100, 0);
        send(0, 301, 0); exp_out("R3 isolated midpoint", 0, mid(100, 301), 1);
        send(0, 0, 0);   exp_out("R2 after isolated", 0, 301, 0);
    endtask

    task automatic t_run();
        do_reset();
        send(0, 1000, 0);
        send(0, 11, 1);   exp_out("R2", 0, 1000, 0);
        send(0, 22, 1);   exp_out("R4 hold 1", 0, 1000, 1);
        send(0, 33, 1);   exp_out("R4 hold 2", 0, 1000, 1);
        send(0, 2000, 0); exp_out("R5 run end interp", 0, mid(1000, 2000), 1);
        send(0, 5, 0);    exp_out("R5 good after run", 0, 2000, 0);
    endtask

    task automatic t_start();
        do_reset();
        send(1, 777, 1); exp_none("R7 first flagged");
        send(1, 888, 1); exp_out("R7 hold zero", 1, 0, 1);
        send(1, 400, 0); exp_out("R7 interp from zero", 1, mid(0, 400), 1);
        send(1, 0, 0);   exp_out("R7 good", 1, 400, 0);
    endtask

    task automatic t_overflow();
        do_reset();
        send(0, 32767, 0);
        send(0, 0, 1);
        send(0, 32767, 0); exp_out("R8 positive limit", 0, 32767, 1);
        send(0, -32768, 0);
        send(0, 0, 1);
        send(0, -32768, 0); exp_out("R8 negative limit", 0, -32768, 1);
        send(0, -3, 0);
        send(0, 0, 1);
        send(0, -4, 0);  exp_out("R8 negative floor", 0, mid(-3, -4), 1);
    endtask

    task automatic t_channels();
        do_reset();
        send(0, 10, 0); exp_none("R6 L first");
        send(1, 50, 0); exp_none("R6 R first");
        send(0, 0, 1);  exp_out("R6 L good", 0, 10, 0);
        send(1, 0, 1);  exp_out("R6 R good", 1, 50, 0);
        send(1, 0, 1);  exp_out("R6 R hold", 1, 50, 1);
        send(0, 30, 0); exp_out("R6 L interp", 0, mid(10, 30), 1);
        send(1, 90, 0); exp_out("R6 R interp", 1, mid(50, 90), 1);
        send(0, 0, 0);  exp_out("R6 L pass", 0, 30, 0);
        send(1, 0, 0);  exp_out("R6 R pass", 1, 90, 0);
    endtask

    task automatic t_stats();
        int code;
        do_reset();
        tick(code); chk("R9 empty window", code, 0);
        send(0, 1, 0); send(0, 2, 0); send(0, 3, 0);
        tick(code); chk("R9 clean window", code, 0);
        send(0, 0, 1); send(0, 4, 0);
        tick(code); chk("R9 interp only", code, 1);
        tick(code); chk("R9 cleared after tick", code, 0);
        send(0, 0, 1); send(0, 0, 1); send(0, 0, 1);
        tick(code); chk("R9 hold only", code, 2);
        send(0, 9, 0);
        tick(code); chk("R9 interp after run", code, 1);
        send(1, 1, 0); send(1, 0, 1); send(1, 0, 1); send(1, 8, 0);
        tick(code); chk("R9 hold and interp", code, 3);
    endtask

    task automatic t_stall();
        do_reset();
        out_ready = 1'b0;
        send(0, 5, 0);
        send(0, 6, 0); exp_out("R10 stalled output", 0, 5, 0);
        in_valid = 1'b1; in_chan = 0; in_data = 16'd7; in_err = 1'b0;
        #1;
        chk("R10 in_ready low", in_ready, 0);
        @(negedge clk);
        chk("R10 data held", $signed(out_data), 5);
        chk("R10 valid held", out_valid, 1);
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R10 released value", $signed(out_data), 6);
        chk("R10 released valid", out_valid, 1);
    endtask

    initial begin
        t_reset();
        t_latency();
        t_isolated();
        t_run();
        t_start();
        t_overflow();
        t_channels();
        t_stats();
        t_stall();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule